// File: doc/BRIEF.md
# Conduction Angle Reference Generator

This block turns a phase-cut mains waveform into a current reference for an LED regulation loop. The input is a one-bit AC-present signal that an analog comparator has already produced. The signal is high while the dimmer conducts and low while it blocks. The block first synchronizes and glitch-filters this signal. It then treats each falling edge of the filtered level as a zero crossing. For every half-cycle it counts the high samples and the total samples, divides them into a 10-bit conduction fraction, and maps that fraction through a piecewise-linear curve to a reference code in millivolts. The result depends only on the duty of the input. It does not depend on mains frequency or amplitude, so a 90 to 130 Hz logic PWM on the same pin works as a dimming command too.

Two watchdogs cover abnormal inputs. If the input stays low with no zero crossing, the reference drops to zero and the soft-start restarts. If the input stays high, the reference goes to full scale. A soft-start ramp limits the applied reference after reset and after every AC-loss event, so the loop never sees a step above the ramp.

The output is a plain level with an update strobe, not a stream. The consumer cannot apply back-pressure. `ref_upd` only tells it that the target behind `ref_mv` has been reloaded, and the code stays valid until the next strobe or ramp step.

Top module: `cond_angle_ref`

## Requirements
- R1: Each half-cycle, the conduction fraction is floor(high_samples*1024/period_samples), where the period runs from one filtered falling edge to the next. The fraction saturates at 1023.
- R2: The measured reference follows a piecewise-linear curve through (fraction 102, 3 mV), (256, 33 mV), (512, 139 mV), (768, 318 mV) and (1003, 548 mV). Each segment is accurate to within 1 mV. The curve gives 3 mV below fraction 102 and 548 mV at or above fraction 1003. ref_mv never exceeds 548.
- R3: The target behind ref_mv is reloaded, with a one-cycle ref_upd pulse, once per completed half-cycle. The first falling edge after reset, AC loss or a stuck-high event only arms the measurement. Between reloads, once the soft-start has finished, ref_mv holds its value.
- R4: If the low input reaches TIMEOUT samples with no falling edge, the target is forced to 0 mV and ss_restart pulses for exactly one cycle.
- R5: If the filtered input stays high for TIMEOUT samples, the target is forced to 548 mV.
- R6: The soft-start ramp starts at 27 mV on reset and on the cycle after ss_restart. It rises by 1 mV every RAMP_DIV samples up to 548 mV. ref_mv is the smaller of the ramp and the target, so it never rises above the ramp.
- R7: An input pulse shorter than FILT_LEN samples does not change the filtered level, so it creates no zero crossing and no extra update.
- R8: Two inputs with the same duty but different half-cycle lengths give the same reference within measurement resolution.
- R9: While reset is held, ref_mv, ref_upd and ss_restart are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ac_in | input | 1 | Asynchronous AC-present level, high while the dimmer conducts |
| ref_mv | output | 10 | Applied current reference, unsigned millivolts |
| ref_upd | output | 1 | One-cycle pulse when the target reference is reloaded |
| ss_restart | output | 1 | One-cycle pulse when AC loss restarts the soft-start |

## Verification
A sweep of duties from 5 % to 99 % checks the flat ends and every segment of the curve. Repeating some duties at a shorter half-cycle separates a true ratio from a raw on-time count. A single-cycle dropout inside the conducting phase separates a filtered level from a raw edge detector. Extended low and high levels exercise the two watchdogs. The ramp value measured at known times after a restart separates a correct initial step and slope from a step to the measured target.

// File: rtl/car_pkg.sv
package car_pkg;
  localparam int FRAC_W   = 10;
  localparam int MV_W     = 10;
  localparam int NPTS     = 5;
  localparam int SLOPE_SH = 12;
  localparam int INIT_MV  = 27;

  typedef logic [FRAC_W-1:0] frac_t;
  typedef logic [MV_W-1:0]   mv_t;

  typedef enum logic [0:0] {DV_IDLE, DV_RUN} dv_state_t;

  function automatic int bp_pct(int i);
    case (i)
      0: return 10;
      1: return 25;
      2: return 50;
      3: return 75;
      default: return 98;
    endcase
  endfunction

  function automatic int bp_y(int i);
    case (i)
      0: return 3;
      1: return 33;
      2: return 139;
      3: return 318;
      default: return 548;
    endcase
  endfunction

  function automatic int bp_x(int i);
    return (bp_pct(i) * (1 << FRAC_W)) / 100;
  endfunction

  function automatic int seg_slope(int i);
    int dx;
    dx = bp_x(i + 1) - bp_x(i);
    return ((bp_y(i + 1) - bp_y(i)) * (1 << SLOPE_SH) + dx / 2) / dx;
  endfunction

  localparam int FULL_MV = bp_y(NPTS - 1);
endpackage

// File: rtl/car_filter.sv
module car_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic ac_i,
  output logic level_o,
  output logic fall_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      run_q   <= '0;
      level_o <= 1'b0;
      fall_o  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], ac_i};
      fall_o <= 1'b0;
      if (tick_i) begin
        if (sync_q[1] != level_o) begin
          if (run_q == CW'(FILT_LEN - 1)) begin
            level_o <= sync_q[1];
            fall_o  <= level_o;
            run_q   <= '0;
          end else begin
            run_q <= run_q + CW'(1);
          end
        end else begin
          run_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/car_divider.sv
module car_divider
  import car_pkg::*;
#(
  parameter int NUM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [NUM_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output frac_t            quot_o
);
  localparam int SW = $clog2(FRAC_W + 1);

  dv_state_t        state_q;
  logic [NUM_W:0]   rem_q;
  logic [NUM_W-1:0] den_q;
  logic [SW-1:0]    step_q;
  logic [NUM_W+1:0] trial;
  logic [NUM_W+1:0] den_ext;

  assign trial   = {rem_q, 1'b0};
  assign den_ext = {2'b00, den_q};
  assign busy_o  = (state_q == DV_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DV_IDLE;
      rem_q   <= '0;
      den_q   <= '0;
      step_q  <= '0;
      quot_o  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        DV_IDLE: begin
          if (start_i) begin
            rem_q   <= {1'b0, num_i};
            den_q   <= den_i;
            step_q  <= SW'(FRAC_W);
            quot_o  <= '0;
            state_q <= DV_RUN;
          end
        end
        default: begin
          if (trial >= den_ext) begin
            rem_q  <= (NUM_W+1)'(trial - den_ext);
            quot_o <= {quot_o[FRAC_W-2:0], 1'b1};
          end else begin
            rem_q  <= (NUM_W+1)'(trial);
            quot_o <= {quot_o[FRAC_W-2:0], 1'b0};
          end
          step_q <= step_q - SW'(1);
          if (step_q == SW'(1)) begin
            done_o  <= 1'b1;
            state_q <= DV_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/car_curve.sv
module car_curve
  import car_pkg::*;
(
  input  frac_t frac_i,
  output mv_t   mv_o
);
  localparam int PW = FRAC_W + SLOPE_SH + 2;

  logic [NPTS-2:0] in_seg;
  mv_t             seg_mv [NPTS-1];

  for (genvar g = 0; g < NPTS - 1; g++) begin : g_seg
    localparam int X0 = bp_x(g);
    localparam int X1 = bp_x(g + 1);
    localparam int Y0 = bp_y(g);
    localparam int SL = seg_slope(g);
    logic [FRAC_W-1:0] dx;
    logic [PW-1:0]     prod;
    assign in_seg[g] = (frac_i >= FRAC_W'(X0)) && (frac_i < FRAC_W'(X1));
    assign dx        = frac_i - FRAC_W'(X0);
    assign prod      = {{(PW-FRAC_W){1'b0}}, dx} * PW'(SL);
    assign seg_mv[g] = mv_t'(Y0) + mv_t'(prod >> SLOPE_SH);
  end

  always_comb begin
    mv_o = mv_t'(bp_y(0));
    if (frac_i >= FRAC_W'(bp_x(NPTS - 1))) begin
      mv_o = mv_t'(FULL_MV);
    end else begin
      for (int i = 0; i < NPTS - 1; i++) begin
        if (in_seg[i]) mv_o = seg_mv[i];
      end
    end
  end
endmodule

// File: rtl/car_softstart.sv
module car_softstart
  import car_pkg::*;
#(
  parameter int RAMP_DIV = 77
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic restart_i,
  output mv_t  ramp_o
);
  localparam int PW = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      ramp_o <= mv_t'(INIT_MV);
    end else if (restart_i) begin
      pre_q  <= '0;
      ramp_o <= mv_t'(INIT_MV);
    end else if (tick_i) begin
      if (pre_q == PW'(RAMP_DIV - 1)) begin
        pre_q <= '0;
        if (ramp_o < mv_t'(FULL_MV)) ramp_o <= ramp_o + mv_t'(1);
      end else begin
        pre_q <= pre_q + PW'(1);
      end
    end
  end
endmodule

// File: rtl/cond_angle_ref.sv
module cond_angle_ref
  import car_pkg::*;
#(
  parameter int SAMPLE_DIV = 500,
  parameter int FILT_LEN   = 4,
  parameter int TIMEOUT    = 3500,
  parameter int RAMP_DIV   = 77
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ac_in,
  output logic [MV_W-1:0] ref_mv,
  output logic            ref_upd,
  output logic            ss_restart
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  logic             tick;
  logic             ac_lvl;
  logic             ac_fall;
  logic [CNT_W-1:0] per_cnt;
  logic [CNT_W-1:0] on_cnt;
  logic [CNT_W-1:0] hi_cnt;
  logic             armed;
  logic             lost;
  logic             stuck;
  logic             div_start;
  logic [CNT_W-1:0] div_num;
  logic [CNT_W-1:0] div_den;
  logic             div_busy;
  logic             div_done;
  frac_t            div_quot;
  mv_t              curve_mv;
  mv_t              target_mv;
  mv_t              ramp_mv;

  if (SAMPLE_DIV <= 1) begin : g_tick_all
    assign tick = 1'b1;
  end else begin : g_tick_div
    localparam int TW = $clog2(SAMPLE_DIV);
    logic [TW-1:0] tcnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tcnt_q <= '0;
      else if (tcnt_q == TW'(SAMPLE_DIV - 1)) tcnt_q <= '0;
      else tcnt_q <= tcnt_q + TW'(1);
    end
    assign tick = (tcnt_q == TW'(SAMPLE_DIV - 1));
  end

  car_filter #(.FILT_LEN(FILT_LEN)) u_filter (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ac_i(ac_in),
    .level_o(ac_lvl), .fall_o(ac_fall)
  );

  car_divider #(.NUM_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start_i(div_start), .num_i(div_num),
    .den_i(div_den), .busy_o(div_busy), .done_o(div_done), .quot_o(div_quot)
  );

  car_curve u_curve (.frac_i(div_quot), .mv_o(curve_mv));

  car_softstart #(.RAMP_DIV(RAMP_DIV)) u_ss (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .restart_i(ss_restart),
    .ramp_o(ramp_mv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt    <= '0;
      on_cnt     <= '0;
      hi_cnt     <= '0;
      armed      <= 1'b0;
      lost       <= 1'b0;
      stuck      <= 1'b0;
      div_start  <= 1'b0;
      div_num    <= '0;
      div_den    <= '0;
      target_mv  <= '0;
      ref_upd    <= 1'b0;
      ss_restart <= 1'b0;
    end else begin
      ref_upd    <= 1'b0;
      ss_restart <= 1'b0;
      div_start  <= 1'b0;
      if (ac_fall) begin
        if (armed && !div_busy && per_cnt != '0) begin
          div_start <= 1'b1;
          div_num   <= on_cnt;
          div_den   <= per_cnt;
        end
        armed   <= 1'b1;
        lost    <= 1'b0;
        stuck   <= 1'b0;
        per_cnt <= '0;
        on_cnt  <= '0;
        hi_cnt  <= '0;
      end else if (tick) begin
        if (per_cnt < CNT_W'(TIMEOUT)) begin
          per_cnt <= per_cnt + CNT_W'(1);
          if (ac_lvl) on_cnt <= on_cnt + CNT_W'(1);
        end
        if (!ac_lvl) hi_cnt <= '0;
        else if (hi_cnt < CNT_W'(TIMEOUT)) hi_cnt <= hi_cnt + CNT_W'(1);
      end
      if (div_done) begin
        target_mv <= curve_mv;
        ref_upd   <= 1'b1;
      end
      if (!ac_fall && !ac_lvl && !lost && per_cnt >= CNT_W'(TIMEOUT)) begin
        lost       <= 1'b1;
        armed      <= 1'b0;
        target_mv  <= '0;
        ref_upd    <= 1'b1;
        ss_restart <= 1'b1;
      end
      if (!ac_fall && ac_lvl && !stuck && hi_cnt >= CNT_W'(TIMEOUT)) begin
        stuck     <= 1'b1;
        armed     <= 1'b0;
        target_mv <= mv_t'(FULL_MV);
        ref_upd   <= 1'b1;
      end
    end
  end

  assign ref_mv = (ramp_mv < target_mv) ? ramp_mv : target_mv;
endmodule

// File: rtl/cond_angle_ref_chk.sv
module cond_angle_ref_chk
  import car_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [MV_W-1:0]  ref_mv,
  input logic             ref_upd,
  input logic             ss_restart,
  input logic [MV_W-1:0]  ramp_mv,
  input logic             div_start,
  input logic [CNT_W-1:0] div_num,
  input logic [CNT_W-1:0] div_den,
  input logic             div_busy,
  input logic             div_done
);
  p_ref_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_mv <= MV_W'(FULL_MV));

  p_ratio_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |-> (div_num <= div_den));

  p_div_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> $past(div_busy));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_mv == MV_W'(FULL_MV) && $past(ramp_mv) == MV_W'(FULL_MV) && !ref_upd)
      |-> $stable(ref_mv));

  p_loss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |-> (ref_mv == '0));

  p_loss_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> !ss_restart);

  p_cap_ramp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_mv <= ramp_mv);

  p_ramp_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_restart |=> (ramp_mv >= $past(ramp_mv)));

  p_restart_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> (ramp_mv == MV_W'(INIT_MV)));
endmodule

bind cond_angle_ref cond_angle_ref_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_mv(ref_mv), .ref_upd(ref_upd),
  .ss_restart(ss_restart), .ramp_mv(ramp_mv), .div_start(div_start),
  .div_num(div_num), .div_den(div_den), .div_busy(div_busy),
  .div_done(div_done)
);

// File: tb/cond_angle_ref_bench.sv
module cond_angle_ref_bench;
  localparam int TOUT  = 2000;
  localparam int RDIV  = 16;
  localparam int NV    = 12;
  localparam int VEC [NV][2] = '{
    '{50, 1000}, '{100, 1000}, '{180, 1000}, '{250, 1000},
    '{400, 1000}, '{500, 1000}, '{620, 1000}, '{750, 1000},
    '{900, 1000}, '{990, 1000}, '{300, 600},  '{450, 600}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ac_in = 1'b0;
  logic [9:0] ref_mv;
  logic       ref_upd;
  logic       ss_restart;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int n_upd   = 0;
  int n_ss    = 0;
  int ss_cyc  = 0;
  bit ended   = 1'b0;

  always #10 clk = ~clk;

  cond_angle_ref #(.SAMPLE_DIV(1), .FILT_LEN(3), .TIMEOUT(TOUT), .RAMP_DIV(RDIV))
    u_cond_angle_ref (.clk(clk), .rst_n(rst_n), .ac_in(ac_in), .ref_mv(ref_mv),
                      .ref_upd(ref_upd), .ss_restart(ss_restart));

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (ref_upd) n_upd++;
      if (ss_restart) begin
        n_ss++;
        ss_cyc = cyc;
      end
    end
  end

  function automatic int exp_mv(int on, int per);
    int f, xs[5], ys[5];
    xs = '{102, 256, 512, 768, 1003};
    ys = '{3, 33, 139, 318, 548};
    f = (on * 1024) / per;
    if (f > 1023) f = 1023;
    if (f < xs[0]) return ys[0];
    if (f >= xs[4]) return ys[4];
    for (int k = 0; k < 4; k++)
      if (f >= xs[k] && f < xs[k+1])
        return ys[k] + ((f - xs[k]) * (ys[k+1] - ys[k])) / (xs[k+1] - xs[k]);
    return 0;
  endfunction

  function automatic int ramp_now();
    int r;
    r = 27 + (cyc - ss_cyc) / RDIV;
    return (r > 548) ? 548 : r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic near(input string req, input int act, input int expv, input int tol);
    check((act >= expv - tol) && (act <= expv + tol), req, act, expv);
  endtask

  task automatic half(input int on, input int per, input bit glitch);
    ac_in = 1'b1;
    for (int k = 0; k < on; k++) begin
      @(negedge clk);
      if (glitch) ac_in = (k != on / 2);
    end
    ac_in = 1'b0;
    repeat (per - on) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    finish_run();
  end

  initial begin
    int u0, ss0;
    repeat (5) @(negedge clk);
    // R9: reset state
    check(ref_mv == 0 && !ref_upd && !ss_restart, "R9", ref_mv, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ref_mv == 0, "R9", ref_mv, 0);

    // R4: low input with no crossing
    repeat (2100) @(negedge clk);
    check(n_ss == 1, "R4 restart pulse", n_ss, 1);
    check(ref_mv == 0, "R4 ref zero", ref_mv, 0);

    // R5 with R6: stuck high, capped by ramp
    ac_in = 1'b1;
    repeat (2200) @(negedge clk);
    near("R6 ramp cap during stuck high", ref_mv, ramp_now(), 2);
    check(ref_mv > 27 && ref_mv < 548, "R6 below full", ref_mv, ramp_now());
    repeat (7000) @(negedge clk);
    check(ref_mv == 548, "R5 stuck high full", ref_mv, 548);

    // R1 R2 R8 R3: vector sweep
    for (int i = 0; i < NV; i++) begin
      u0 = n_upd;
      repeat (3) half(VEC[i][0], VEC[i][1], 1'b0);
      repeat (40) @(negedge clk);
      near((VEC[i][1] == 600) ? "R8 short period" : "R2 R1 curve",
           ref_mv, exp_mv(VEC[i][0], VEC[i][1]), 3);
      if (i > 0) check(n_upd - u0 == 3, "R3 one update per half-cycle", n_upd - u0, 3);
    end

    // R3: hold between updates
    u0 = n_upd;
    ac_in = 1'b1;
    repeat (300) @(negedge clk);
    check(n_upd == u0, "R3 no update mid half-cycle", n_upd - u0, 0);
    near("R3 hold mid half-cycle", ref_mv, exp_mv(450, 600), 3);
    ac_in = 1'b0;
    repeat (300) @(negedge clk);

    // R7: single-cycle dropout inside conduction
    u0 = n_upd;
    repeat (3) half(500, 1000, 1'b1);
    repeat (40) @(negedge clk);
    check(n_upd - u0 == 3, "R7 glitch adds no crossing", n_upd - u0, 3);
    near("R7 glitch ratio", ref_mv, exp_mv(500, 1000), 3);

    // R4 then R6: loss and soft-start recovery
    ss0 = n_ss;
    repeat (2100) @(negedge clk);
    check(n_ss == ss0 + 1, "R4 second loss", n_ss - ss0, 1);
    check(ref_mv == 0, "R4 ref zero after loss", ref_mv, 0);
    repeat (3) half(980, 1000, 1'b0);
    repeat (40) @(negedge clk);
    near("R6 ramp after restart", ref_mv, ramp_now(), 2);
    check(ref_mv < exp_mv(980, 1000), "R6 no step to target", ref_mv, ramp_now());
    finish_run();
  end
endmodule